// File: doc/BRIEF.md
# Configuration Image Header Loader

This block feeds a configuration image, arriving as a byte stream, into the byte-wide configuration port of a programmable target. A start pulse opens a session. The block sends a one-cycle reset request to the target, then offers one filler byte of value 0x00. Only after that does it accept image bytes.

The image opens with a 16-byte header. Bytes 0 to 3 hold the payload length, most significant byte first. Bytes 4 to 7, 8 to 11 and 12 to 15 carry a version word, a date word and a reserved word. All four words are captured into status outputs, and only the length affects behaviour. The block forwards exactly the declared number of payload bytes, then drives a fixed run of 0x00 pad bytes and ends in a done or an error state.

The input side and the output side each use a valid/ready byte handshake, and the input marks its final byte with a last flag. The target reports a load failure on an error input. If that input is seen during the session, the block finishes in error and leaves the interrupt enable low. A clean finish raises the interrupt enable.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset the block is idle. in_ready_o, out_valid_o, tgt_reset_o, busy_o, done_o, err_o and irq_en_o are all 0, and err_code_o is 0.
- R2: A start pulse seen while idle, done or in error makes tgt_reset_o high for exactly the next cycle. The block then offers a single 0x00 byte on the output. in_ready_o stays 0 until that byte has been accepted.
- R3: The first 16 accepted input bytes form the header, and none of them appears on the output. Bytes 0..3, 4..7, 8..11 and 12..15 are packed big-endian into len_o, ver_o, date_o and rsvd_o respectively. A start pulse clears all four words to 0.
- R4: After the header, exactly len_o input bytes are forwarded to the output in order, one per handshake. During this phase in_ready_o follows out_ready_i, so backpressure stalls the input without losing or repeating bytes.
- R5: After the payload, exactly PAD_BYTES (default 5) bytes of value 0x00 are driven on the output. No input byte is consumed while they are sent, or after them.
- R6: If in_last_i comes with any header byte before byte 15, the session ends with err_o=1 and err_code_o=1 (short image), and nothing beyond the filler byte is forwarded.
- R7: If in_last_i comes with header byte 15 while the length is nonzero, or with a payload byte that is not the final declared one, the session ends with err_o=1 and err_code_o=2 (truncated). That byte is forwarded if it is a payload byte, and no pad bytes follow.
- R8: If tgt_err_i is high in any cycle from the reset request through the handshake of the last pad byte, the session ends with err_o=1, err_code_o=3 and irq_en_o=0. Otherwise it ends with done_o=1, irq_en_o=1 and err_code_o=0. done_o and err_o are never both 1.
- R9: done_o, err_o, err_code_o and irq_en_o hold until the next start pulse. A start pulse while busy_o=1 is ignored: it produces no reset request and does not disturb the session.
- R10: A header with length 0 goes straight to the pad bytes, and the session completes without needing further input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start pulse |
| in_valid_i | input | 1 | Image byte valid |
| in_data_i | input | 8 | Image byte |
| in_last_i | input | 1 | Marks the final image byte |
| in_ready_o | output | 1 | Image byte accepted when high with in_valid_i |
| out_valid_o | output | 1 | Configuration byte valid |
| out_data_o | output | 8 | Configuration byte |
| out_ready_i | input | 1 | Target accepts the configuration byte |
| tgt_reset_o | output | 1 | One-cycle reset request to the target |
| tgt_err_i | input | 1 | Target reports a load error |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | Session completed cleanly (sticky) |
| err_o | output | 1 | Session ended in error (sticky) |
| err_code_o | output | 2 | 0 none, 1 short, 2 truncated, 3 target error |
| irq_en_o | output | 1 | Interrupt enable, high only after clean completion |
| len_o | output | 32 | Captured payload length |
| ver_o | output | 32 | Captured version word |
| date_o | output | 32 | Captured date word |
| rsvd_o | output | 32 | Captured reserved word |

## Verification
The bench runs sessions under random input gaps and random output backpressure. A design that drops or repeats a byte under stall shows up as a payload mismatch, and so does a design that lets a header byte leak out or accepts input before the filler byte. Each stream-termination boundary gets a directed case:
- an image that ends inside the header;
- an image that ends exactly at the header with a nonzero length;
- an image that ends one byte short of its payload;
- a zero-length image;
- an image with surplus bytes after the payload.
An off-by-one in the length or pad counter shows up as a wrong output count or a wrong amount of input consumed. Two further cases inject a target error early and pulse start mid-session. A design that forgot the early error would report done, and one that honoured the stray start would emit a second reset request.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  localparam int unsigned HDR_BYTES = 16;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WORD_B    = WORD_W / 8;
  localparam int unsigned HDR_WORDS = HDR_BYTES / WORD_B;
  localparam int unsigned IDX_W     = $clog2(HDR_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_PRE, ST_HDR, ST_PAY, ST_PAD, ST_DONE, ST_ERR
  } ldr_state_e;

  typedef enum logic [1:0] {
    EC_NONE   = 2'd0,
    EC_SHORT  = 2'd1,
    EC_TRUNC  = 2'd2,
    EC_TARGET = 2'd3
  } ldr_err_e;
endpackage

// File: rtl/cfg_hdr_capture.sv
module cfg_hdr_capture
  import cfg_ldr_pkg::*;
(
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 clr_i,
  input  logic                                 we_i,
  input  logic [IDX_W-1:0]                     idx_i,
  input  logic [7:0]                           byte_i,
  output logic [HDR_WORDS-1:0][WORD_W-1:0]     words_o
);
  for (genvar w = 0; w < HDR_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_B; b++) begin : g_byte
      localparam int unsigned POS = w * WORD_B + b;
      localparam int unsigned MSB = WORD_W - 1 - 8 * b;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          words_o[w][MSB -: 8] <= '0;
        end else if (clr_i) begin
          words_o[w][MSB -: 8] <= '0;
        end else if (we_i && idx_i == IDX_W'(POS)) begin
          words_o[w][MSB -: 8] <= byte_i;  // byte 0 of each word is its MSB
        end
      end
    end
  end

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (words_o == '0));
endmodule

// File: rtl/cfg_len_counter.sv
module cfg_len_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             is_one_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign is_one_o = (cnt_q == CNT_W'(1));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0));
  p_load_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/cfg_ldr_ctrl.sv
module cfg_ldr_ctrl
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned PAD_BYTES = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  input  logic             out_ready_i,
  input  logic             tgt_err_i,
  input  logic             len_zero_i,
  input  logic             cnt_one_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             pass_o,
  output logic             tgt_reset_o,
  output logic             hdr_clr_o,
  output logic             hdr_we_o,
  output logic [IDX_W-1:0] hdr_idx_o,
  output logic             cnt_load_o,
  output logic             cnt_dec_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       err_code_o,
  output logic             irq_en_o
);
  localparam int unsigned PAD_W = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;
  localparam logic [PAD_W-1:0] PAD_LAST = PAD_W'(PAD_BYTES - 1);
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_BYTES - 1);

  ldr_state_e       st_q, st_d;
  ldr_err_e         ec_q, ec_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PAD_W-1:0] pad_q, pad_d;
  logic             seen_q, seen_d;
  logic             can_start;

  assign can_start = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR);

  always_comb begin
    st_d        = st_q;
    ec_d        = ec_q;
    idx_d       = idx_q;
    pad_d       = pad_q;
    seen_d      = seen_q | (busy_o & tgt_err_i);
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    pass_o      = 1'b0;
    hdr_clr_o   = 1'b0;
    hdr_we_o    = 1'b0;
    cnt_load_o  = 1'b0;
    cnt_dec_o   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start_i) begin
          st_d      = ST_RST;
          ec_d      = EC_NONE;
          seen_d    = 1'b0;
          hdr_clr_o = 1'b1;
        end
      end
      ST_RST: st_d = ST_PRE;
      ST_PRE: begin
        out_valid_o = 1'b1;
        if (out_ready_i) begin
          st_d  = ST_HDR;
          idx_d = '0;
        end
      end
      ST_HDR: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          hdr_we_o = 1'b1;
          idx_d    = idx_q + IDX_W'(1);
          if (idx_q == HDR_LAST) begin
            if (len_zero_i) begin
              st_d  = ST_PAD;
              pad_d = '0;
            end else if (in_last_i) begin
              st_d = ST_ERR;
              ec_d = EC_TRUNC;
            end else begin
              st_d       = ST_PAY;
              cnt_load_o = 1'b1;
            end
          end else if (in_last_i) begin
            st_d = ST_ERR;
            ec_d = EC_SHORT;
          end
        end
      end
      ST_PAY: begin
        pass_o      = 1'b1;
        out_valid_o = in_valid_i;
        in_ready_o  = out_ready_i;
        if (in_valid_i && out_ready_i) begin
          cnt_dec_o = 1'b1;
          if (cnt_one_i) begin
            st_d  = ST_PAD;
            pad_d = '0;
          end else if (in_last_i) begin
            st_d = ST_ERR;
            ec_d = EC_TRUNC;
          end
        end
      end
      ST_PAD: begin
        out_valid_o = 1'b1;
        if (out_ready_i) begin
          if (pad_q == PAD_LAST) begin
            if (seen_q || tgt_err_i) begin
              st_d = ST_ERR;
              ec_d = EC_TARGET;
            end else begin
              st_d = ST_DONE;
            end
          end else begin
            pad_d = pad_q + PAD_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ec_q   <= EC_NONE;
      idx_q  <= '0;
      pad_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ec_q   <= ec_d;
      idx_q  <= idx_d;
      pad_q  <= pad_d;
      seen_q <= seen_d;
    end
  end

  assign hdr_idx_o   = idx_q;
  assign tgt_reset_o = (st_q == ST_RST);
  assign busy_o      = !can_start;
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = (st_q == ST_ERR);
  assign err_code_o  = ec_q;
  assign irq_en_o    = done_o;

  p_rst_then_dummy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_reset_o |=> (!tgt_reset_o && out_valid_o && !in_ready_o));
  p_hdr_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_we_o |-> !out_valid_o);
  p_pad_no_input_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !pass_o) |-> !in_ready_o);
  p_short_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_we_o && in_last_i && hdr_idx_o != HDR_LAST) |=> (err_o && err_code_o == EC_SHORT));
  p_trunc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_o && in_last_i && !cnt_one_i) |=> (err_o && err_code_o == EC_TRUNC));
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !irq_en_o);
  p_sticky_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  p_sticky_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> (err_o && $stable(err_code_o)));
  p_busy_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tgt_reset_o) |=> !tgt_reset_o);
  p_zero_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_we_o && hdr_idx_o == HDR_LAST && len_zero_i) |=> (out_valid_o && !pass_o));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned PAD_BYTES = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  input  logic        out_ready_i,
  output logic        tgt_reset_o,
  input  logic        tgt_err_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [1:0]  err_code_o,
  output logic        irq_en_o,
  output logic [31:0] len_o,
  output logic [31:0] ver_o,
  output logic [31:0] date_o,
  output logic [31:0] rsvd_o
);
  logic [HDR_WORDS-1:0][WORD_W-1:0] words;
  logic             pass, hdr_clr, hdr_we, cnt_load, cnt_dec, cnt_one;
  logic [IDX_W-1:0] hdr_idx;

  cfg_ldr_ctrl #(.PAD_BYTES(PAD_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .out_ready_i (out_ready_i),
    .tgt_err_i   (tgt_err_i),
    .len_zero_i  (words[0] == '0),
    .cnt_one_i   (cnt_one),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .pass_o      (pass),
    .tgt_reset_o (tgt_reset_o),
    .hdr_clr_o   (hdr_clr),
    .hdr_we_o    (hdr_we),
    .hdr_idx_o   (hdr_idx),
    .cnt_load_o  (cnt_load),
    .cnt_dec_o   (cnt_dec),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o),
    .irq_en_o    (irq_en_o)
  );

  cfg_hdr_capture u_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hdr_clr),
    .we_i    (hdr_we),
    .idx_i   (hdr_idx),
    .byte_i  (in_data_i),
    .words_o (words)
  );

  cfg_len_counter #(.CNT_W(WORD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cnt_load),
    .val_i    (words[0]),
    .dec_i    (cnt_dec),
    .is_one_o (cnt_one)
  );

  assign out_data_o = pass ? in_data_i : 8'h00;
  assign len_o  = words[0];
  assign ver_o  = words[1];
  assign date_o = words[2];
  assign rsvd_o = words[3];

  p_pass_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !pass) |-> (out_data_o == 8'h00));
endmodule

// File: tb/cfg_image_loader_bench.sv
module cfg_image_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PADN = 5;

  logic clk = 0, rst_n = 0;
  logic start = 0, in_valid = 0, in_last = 0, out_ready = 0, tgt_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, tgt_reset, busy, done, err, irq_en;
  logic [7:0] out_data;
  logic [1:0] err_code;
  logic [31:0] len_w, ver_w, date_w, rsvd_w;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] img [0:63];
  logic [7:0] got [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_image_loader #(.PAD_BYTES(PADN)) u_cfg_image_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .tgt_reset_o(tgt_reset), .tgt_err_i(tgt_err),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(err_code), .irq_en_o(irq_en),
    .len_o(len_w), .ver_o(ver_w), .date_o(date_w), .rsvd_o(rsvd_w)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(int len, int supplied, bit terr);
    if (supplied < 16) return 1;
    if (len > 0 && supplied < 16 + len) return 2;
    if (terr) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] hdr_word(int k);
    return {img[4*k], img[4*k+1], img[4*k+2], img[4*k+3]};
  endfunction

  task automatic run_session(input int len, input int supplied, input int terr_cyc,
                             input int busy_start_cyc);
    int code, n_out, idx, early_in, extra_rst, exp_n, exp_cons;
    bit ended, mism;
    for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
    img[0] = 8'(len >> 24); img[1] = 8'(len >> 16);
    img[2] = 8'(len >> 8);  img[3] = 8'(len);
    code = exp_code(len, supplied, terr_cyc >= 0);
    n_out = 0; idx = 0; early_in = 0; extra_rst = 0; ended = 0;

    @(negedge clk); start = 1; in_valid = 0; out_ready = 0; tgt_err = 0;
    @(negedge clk); start = 0; #1;
    chk(tgt_reset == 1 && in_ready == 0, "R2", "reset request after start", tgt_reset, 1);

    for (int cyc = 0; cyc < 3000 && !ended; cyc++) begin
      @(negedge clk);
      start     = (cyc == busy_start_cyc);
      tgt_err   = (cyc == terr_cyc);
      in_valid  = (idx < supplied) && ($urandom % 4 != 0);
      in_data   = img[idx];
      in_last   = (idx == supplied - 1);
      out_ready = ($urandom % 4 != 0);
      #1;
      if (done || err) begin
        ended = 1;
      end else begin
        if (tgt_reset) extra_rst++;
        if (in_valid && in_ready) begin
          if (n_out == 0) early_in++;
          idx++;
        end
        if (out_valid && out_ready) begin
          if (n_out < 128) got[n_out] = out_data;
          n_out++;
        end
      end
    end
    in_valid = 0; start = 0; tgt_err = 0; out_ready = 0;

    chk(ended, "R8", "session finished", ended, 1);
    chk(early_in == 0, "R2", "input accepted before filler byte", early_in, 0);
    chk(extra_rst == 0, "R9", "reset requests during session", extra_rst, 0);
    chk(err_code == 2'(code) && err == (code != 0) && done == (code == 0),
        (code == 1) ? "R6" : (code == 2) ? "R7" : "R8", "outcome code", err_code, code);
    chk(irq_en == (code == 0), "R8", "interrupt enable", irq_en, code == 0);

    if (code == 0 || code == 3) begin
      exp_n = 1 + len + PADN; exp_cons = 16 + len;
    end else if (code == 2) begin
      exp_n = 1 + supplied - 16; exp_cons = supplied;
    end else begin
      exp_n = 1; exp_cons = supplied;
    end
    chk(n_out == exp_n, (code == 0) ? "R5" : "R4", "output byte count", n_out, exp_n);
    chk(idx == exp_cons, "R5", "input bytes consumed", idx, exp_cons);
    mism = 0;
    if (n_out == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        logic [7:0] e;
        if (i == 0) e = 8'h00;
        else if (i <= exp_n - 1 - ((code == 0 || code == 3) ? PADN : 0)) e = img[15 + i];
        else e = 8'h00;
        if (got[i] !== e) mism = 1;
      end
      chk(!mism, "R4", "output byte sequence (filler, payload, pad)", mism, 0);
    end
    if (supplied >= 16) begin
      chk(len_w == hdr_word(0), "R3", "length word", len_w, hdr_word(0));
      chk(ver_w == hdr_word(1), "R3", "version word", ver_w, hdr_word(1));
      chk(date_w == hdr_word(2), "R3", "date word", date_w, hdr_word(2));
      chk(rsvd_w == hdr_word(3), "R3", "reserved word", rsvd_w, hdr_word(3));
    end
    repeat (4) @(negedge clk);
    #1;
    chk(done == (code == 0) && err == (code != 0) && err_code == 2'(code) && !busy,
        "R9", "sticky outcome", {done, err, err_code}, code);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!in_ready && !out_valid && !tgt_reset && !busy && !done && !err && !irq_en
        && err_code == 0, "R1", "reset outputs", {in_ready, out_valid, busy, done, err}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!busy && !done && !err && len_w == 0, "R1", "idle after reset release", busy, 0);

    run_session(6, 22, -1, -1);   // R4 plain image
    run_session(0, 16, -1, -1);   // R10 zero length
    run_session(0, 20, -1, -1);   // R10 zero length with surplus input
    run_session(9, 7, -1, -1);    // R6 short header
    run_session(3, 16, -1, -1);   // R7 ends at header end
    run_session(8, 23, -1, -1);   // R7 one byte short
    run_session(5, 30, -1, -1);   // R5 surplus bytes not consumed
    run_session(12, 28, 2, -1);   // R8 early target error
    run_session(10, 26, -1, 6);   // R9 start while busy
    run_session(1, 1, -1, -1);    // R6 single byte image
    for (int s = 0; s < 16; s++) begin
      int l, sup, mode;
      l = int'($urandom % 41);
      mode = int'($urandom % 4);
      case (mode)
        1: sup = 1 + int'($urandom % 15);
        2: sup = (l == 0) ? 16 : 16 + int'($urandom % l);
        default: sup = 16 + l + int'($urandom % 4);
      endcase
      run_session(l, sup, ($urandom % 4 == 0) ? int'($urandom % 5) : -1, -1);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule